// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter with Compare

This block is an 8-bit up-counter driven through a clock-select prescaler. It has a small register bus for programming and for reading back state. A 3-bit clock-select code either stops the counter or selects one of seven divide ratios. Each prescaler tick advances the counter by one. Two kinds of event are detected: a wrap from the top count back to zero (overflow), and the counter advancing past a programmed compare value (compare). A mode setting turns the compare event into a period reset, which reloads the counter with zero.

Each event either pulses an interrupt-request output or sets a sticky flag. The choice depends on that event's enable bit. Software clears a flag by writing a one to it. The counter can be loaded at any time, and all later events are timed from the loaded value.

The register bus has a write strobe, a 3-bit address and combinational read data. Registers by address:
- 0: control
- 1: counter
- 2: compare
- 3: enables
- 4: flags

Top module: `tmr8_unit`

## Requirements
- R1: Clock-select field control[2:0] picks the count rate. Code 0 gives no counting. Codes 1 to 7 advance the counter once every 1, 8, 32, 64, 128, 256 or 1024 input clocks respectively.
- R2: While the clock-select field is 0 the counter holds its value. Writing a non-zero code resumes counting from the held value.
- R3: The counter goes from 255 to 0 on a tick. That tick is an overflow event.
- R4: With compare value X, the tick that moves the counter from X to X+1 is a compare event.
- R5: Period-reset mode is active when control[4]=1 and control[3]=0. In this mode a compare event loads the counter with 0 instead of X+1. Any other setting of those two bits leaves counting unaffected.
- R6: On an event whose enable bit is set, the matching request output (ovf_irq_o or cmp_irq_o) is high for exactly one cycle, and the matching flag is left or made clear. Enable bits: enables[0] for overflow, enables[1] for compare.
- R7: On an event whose enable bit is clear, the matching flag is set. Flag bits: flags[0] for overflow, flags[1] for compare.
- R8: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R9: A write to the counter register takes effect at that clock edge, overriding any tick in the same cycle. Later counting continues from the written value.
- R10: A compare write of 0, 0xFE or 0xFF stores 1. Any other value is stored unchanged.
- R11: Whenever a control write changes the clock-select code, the prescaler's divider restarts from zero.
- R12: Reset clears every register, the counter and the divider. The control register reads back only bits [4:0], with the upper bits reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| ovf_irq_o | output | 1 | One-cycle overflow request |
| cmp_irq_o | output | 1 | One-cycle compare request |

## Verification
The hardest cases to reach from the ports concern the prescaler divider, which is never visible directly. The divider can only be observed through the exact cycle in which the counter next moves. To test the restart rule, the bench switches from ÷64 to ÷32 after 40 clocks, when the old divider is deep into its count. It then checks the count one cycle before and exactly at the 32nd edge. The other difficult case is clearing a flag by taking an interrupt. Here the stimulus sets a compare flag with its enable off, then turns the enable on. It then loads the counter to the compare value, so the next tick raises the event.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int CS_W      = 3;
  localparam int MAX_SHIFT = 10;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_CMP  = 3'd2;
  localparam logic [2:0] A_EN   = 3'd3;
  localparam logic [2:0] A_FLAG = 3'd4;

  // log2 of the divide ratio for a non-zero clock-select code
  function automatic logic [3:0] shift_of(input logic [CS_W-1:0] cs);
    case (cs)
      3'd2:    shift_of = 4'd3;
      3'd3:    shift_of = 4'd5;
      3'd4:    shift_of = 4'd6;
      3'd5:    shift_of = 4'd7;
      3'd6:    shift_of = 4'd8;
      3'd7:    shift_of = 4'd10;
      default: shift_of = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
#(
  parameter int DIV_W = MAX_SHIFT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CS_W-1:0] cs_i,
  input  logic            restart_i,
  output logic            tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic             run;

  assign run    = (cs_i != '0);
  assign span   = ((DIV_W+1)'(1) << shift_of(cs_i)) - (DIV_W+1)'(1);
  assign tick_o = run && (div_q == span[DIV_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  div_q <= '0;
    else if (restart_i || tick_o) div_q <= '0;
    else if (run)                 div_q <= div_q + 1'b1;
  end

  a_r11_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (div_q == '0));
  a_r1_tick_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (cs_i != '0));
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctc_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o,
  output logic             cmp_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv       = tick_i && !we_i;
  assign ovf_evt_o = adv && (cnt_q == '1);
  assign cmp_evt_o = adv && (cnt_q == cmp_i);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (we_i)                 cnt_q <= wdata_i;
    else if (cmp_evt_o && ctc_i)   cnt_q <= '0;
    else if (adv)                  cnt_q <= cnt_q + 1'b1;
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !we_i) |=> $stable(cnt_q));
  a_r5_ctc_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_evt_o && ctc_i) |=> (cnt_q == '0));
  a_r4_past_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_evt_o && !ctc_i) |=> (cnt_q == $past(cmp_i) + 1'b1));
  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             ovf_irq_o,
  output logic             cmp_irq_o
);
  localparam int CTRL_W = 5;
  localparam int N_EVT  = 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [N_EVT-1:0]  en_q, flag_q, irq_q, evt;
  logic [CNT_W-1:0]  cnt;
  logic              tick, ctc, restart;
  logic              wr_ctrl, wr_cnt, wr_cmp, wr_en, wr_flag;
  logic [CNT_W-1:0]  cmp_wval;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_cnt  = wr_en_i && (addr_i == A_CNT);
  assign wr_cmp  = wr_en_i && (addr_i == A_CMP);
  assign wr_en   = wr_en_i && (addr_i == A_EN);
  assign wr_flag = wr_en_i && (addr_i == A_FLAG);

  assign ctc     = ctrl_q[4] && !ctrl_q[3];
  assign restart = wr_ctrl && (wdata_i[CS_W-1:0] != ctrl_q[CS_W-1:0]);

  // keep compare away from 0 and the top two counts
  assign cmp_wval = (wdata_i == '0 || wdata_i == '1 || wdata_i == {{(CNT_W-1){1'b1}}, 1'b0})
                    ? CNT_W'(1) : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      en_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr_cmp)  cmp_q  <= cmp_wval;
      if (wr_en)   en_q   <= wdata_i[N_EVT-1:0];
    end
  end

  tmr8_prescaler u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (ctrl_q[CS_W-1:0]),
    .restart_i(restart),
    .tick_o   (tick)
  );

  tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .ctc_i    (ctc),
    .we_i     (wr_cnt),
    .wdata_i  (wdata_i),
    .cmp_i    (cmp_q),
    .cnt_o    (cnt),
    .ovf_evt_o(evt[0]),
    .cmp_evt_o(evt[1])
  );

  for (genvar b = 0; b < N_EVT; b++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[b] <= 1'b0;
        irq_q[b]  <= 1'b0;
      end else begin
        irq_q[b] <= evt[b] && en_q[b];
        if (evt[b])                      flag_q[b] <= !en_q[b];
        else if (wr_flag && wdata_i[b])  flag_q[b] <= 1'b0;
      end
    end

    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q[b] |=> !irq_q[b]);
    a_r6_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q[b] |-> !flag_q[b]);
  end

  assign ovf_irq_o = irq_q[0];
  assign cmp_irq_o = irq_q[1];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = CNT_W'(ctrl_q);
      A_CNT:   rdata_o = cnt;
      A_CMP:   rdata_o = cmp_q;
      A_EN:    rdata_o = CNT_W'(en_q);
      A_FLAG:  rdata_o = CNT_W'(flag_q);
      default: rdata_o = '0;
    endcase
  end

  a_r10_cmp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_q != '1) && (cmp_q != {{(CNT_W-1){1'b1}}, 1'b0}));
  a_r10_zero_coerced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmp && wdata_i == '0) |=> (cmp_q == CNT_W'(1)));
endmodule

// File: tb/tmr8_unit_bench.sv
module tmr8_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ovf_irq_o, cmp_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tmr8_unit u_tmr8_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ovf_irq_o(ovf_irq_o), .cmp_irq_o(cmp_irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // call only at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr_i = a; #1; v = int'(rdata_o);
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic prep(input logic [7:0] cnt_v, input logic [7:0] cmp_v);
    wr(0, 8'h00); wr(3, 8'h00); wr(1, cnt_v); wr(2, cmp_v); wr(4, 8'h03);
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R12 reset reg", v, 0);
    end
    chk("R12 reset irq", int'(ovf_irq_o) + int'(cmp_irq_o), 0);
    wr(0, 8'hE0); rd(0, v); chk("R12 ctrl upper bits", v, 0);
  endtask

  task automatic t_ratios;
    int v;
    int r;
    for (int cs = 1; cs < 8; cs++) begin
      case (cs)
        1: r = 1; 2: r = 8; 3: r = 32; 4: r = 64;
        5: r = 128; 6: r = 256; default: r = 1024;
      endcase
      prep(8'd0, 8'd200);
      wr(0, 8'(cs));
      waitn(2*r - 1); rd(1, v); chk("R1 before 2nd tick", v, (r == 1) ? 1 : 1);
      waitn(1);       rd(1, v); chk("R1 at 2nd tick", v, 2);
    end
  endtask

  task automatic t_stop;
    int v, h;
    prep(8'd10, 8'd200);
    wr(0, 8'h01); waitn(3);
    wr(0, 8'h00); rd(1, h);
    waitn(20); rd(1, v); chk("R2 held while stopped", v, h);
    wr(0, 8'h01); waitn(5); rd(1, v); chk("R2 resume from held", v, h + 5);
  endtask

  task automatic t_overflow;
    int v;
    prep(8'd250, 8'd100);
    wr(0, 8'h01);
    waitn(5); rd(1, v); chk("R3 at 255", v, 255);
    rd(4, v); chk("R3 no flag yet", v & 1, 0);
    waitn(1); rd(1, v); chk("R3 wraps to 0", v, 0);
    rd(4, v); chk("R7 overflow flag", v & 1, 1);
    wr(1, 8'd7); rd(1, v); chk("R9 load now", v, 7);
    waitn(3); rd(1, v); chk("R9 count from load", v, 10);
  endtask

  task automatic t_compare;
    int v;
    prep(8'd0, 8'd10);
    wr(0, 8'h01);
    waitn(10); rd(4, v); chk("R4 no compare at X", (v >> 1) & 1, 0);
    waitn(1);  rd(4, v); chk("R4 compare at X+1", (v >> 1) & 1, 1);
    rd(1, v); chk("R4 keeps running", v, 11);
  endtask

  task automatic t_ctc;
    int v;
    prep(8'd0, 8'd5);
    wr(0, 8'h11);
    waitn(5); rd(1, v); chk("R5 reach X", v, 5);
    waitn(1); rd(1, v); chk("R5 reload 0", v, 0);
    waitn(1); rd(1, v); chk("R5 count again", v, 1);
    prep(8'd0, 8'd5);
    wr(0, 8'h19); rd(0, v); chk("R12 ctrl readback", v, 8'h19);
    waitn(6); rd(1, v); chk("R5 both bits set no reload", v, 6);
  endtask

  task automatic t_irq;
    int v;
    prep(8'd0, 8'd5);
    wr(3, 8'h02); wr(0, 8'h01);
    waitn(5); chk("R6 no cmp irq early", int'(cmp_irq_o), 0);
    waitn(1); chk("R6 cmp irq pulse", int'(cmp_irq_o), 1);
    rd(4, v); chk("R6 cmp flag clear", (v >> 1) & 1, 0);
    waitn(1); chk("R6 cmp irq one cycle", int'(cmp_irq_o), 0);
    prep(8'd254, 8'd100);
    wr(3, 8'h01); wr(0, 8'h01);
    waitn(1); chk("R6 no ovf irq early", int'(ovf_irq_o), 0);
    waitn(1); chk("R6 ovf irq pulse", int'(ovf_irq_o), 1);
    rd(4, v); chk("R6 ovf flag clear", v & 1, 0);
    // flag set while masked, cleared when taken
    prep(8'd0, 8'd3);
    wr(0, 8'h01); waitn(4);
    rd(4, v); chk("R7 cmp flag set", (v >> 1) & 1, 1);
    wr(3, 8'h02);
    rd(4, v); chk("R6 flag kept by enable write", (v >> 1) & 1, 1);
    wr(1, 8'd3); waitn(1);
    rd(4, v); chk("R6 flag cleared when taken", (v >> 1) & 1, 0);
    chk("R6 irq when taken", int'(cmp_irq_o), 1);
  endtask

  task automatic t_w1c;
    int v;
    prep(8'd254, 8'd3);
    wr(0, 8'h01); waitn(6);
    wr(0, 8'h00);
    rd(4, v); chk("R7 both flags", v, 3);
    wr(4, 8'h00); rd(4, v); chk("R8 zero no effect", v, 3);
    wr(4, 8'h01); rd(4, v); chk("R8 clear overflow only", v, 2);
    wr(4, 8'h02); rd(4, v); chk("R8 clear compare", v, 0);
  endtask

  task automatic t_coerce;
    int v;
    wr(2, 8'h00); rd(2, v); chk("R10 zero", v, 1);
    wr(2, 8'hFE); rd(2, v); chk("R10 FE", v, 1);
    wr(2, 8'hFF); rd(2, v); chk("R10 FF", v, 1);
    wr(2, 8'hFD); rd(2, v); chk("R10 FD kept", v, 8'hFD);
    wr(2, 8'h07); rd(2, v); chk("R10 7 kept", v, 7);
  endtask

  task automatic t_restart;
    int v;
    prep(8'd0, 8'd200);
    wr(0, 8'h04); waitn(40);
    wr(0, 8'h03);
    waitn(31); rd(1, v); chk("R11 no tick before new period", v, 0);
    waitn(1);  rd(1, v); chk("R11 tick after new period", v, 1);
  endtask

  initial begin
    waitn(3);
    rst_ni = 1'b1;
    waitn(1);
    t_reset;
    t_ratios;
    t_stop;
    t_overflow;
    t_compare;
    t_ctc;
    t_irq;
    t_w1c;
    t_coerce;
    t_restart;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule